// File: doc/BRIEF.md
# Carry-Save Load-and-Expire Timer

A one-shot timer that keeps its count in redundant form: a sum vector and a carry vector. Each cycle, every bit position acts as a half adder on its own sum and carry bits. The result goes one place up. A carry therefore moves at most one bit per cycle. The logic depth between registers stays at a single gate, whatever the width.

A load strobe takes in a W-bit preset word and clears the expiry state. From the next cycle on, the timer advances by one each cycle. A carry that leaves the top bit position sets a sticky expiry flag. The flag stays set until the next load.

Two outputs report expiry:

- A level output. It is the combinational next value of the expiry flag, and it is held low during any load cycle.
- A one-cycle pulse, raised on the rising edge of the level output.

The only way to initialise the block is to assert load. The mapping from preset to delay is fixed: with n = 2^W + W - 2 - P, the level output goes high on the (n+1)-th cycle after the load cycle.

Top module: `csa_expiry_timer`

## Requirements
- R1: On the first cycle after a load cycle, with load low, the level output is low for every preset value.
- R2: In any cycle where load is high, the level output is low, whatever the timer state.
- R3: After a load at cycle t with preset P, and load low from t+1 on, the level output at t+k is high exactly when k > n, where n = 2^W + W - 2 - P.
- R4: Once the level output is high, it stays high on every later cycle until load is asserted again.
- R5: The pulse output is high at t+k only for k = n+1, and it never stays high for two cycles in a row.
- R6: A load asserted while the timer is counting and not yet expired restarts the timer. The old pending expiry is dropped, and the new expiry falls n'+1 cycles after the new load, where n' is computed from the new preset.
- R7: A load asserted after expiry drops the level output in the load cycle. No pulse follows until the new countdown expires.
- R8: The width parameter W must be at least 2, checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| load_i | input | 1 | Load strobe; captures the preset and clears expiry |
| preset_i | input | W | Preset word taken in on a load cycle |
| done_o | output | 1 | Expiry level, low during load, sticky otherwise |
| done_pulse_o | output | 1 | One-cycle pulse on the rising edge of done_o |

## Verification
The hardest case to reach is a load that arrives while carries are still moving up the carry vector. The redundant state must then be discarded completely, with no stray carry reaching the top bit after the restart. The bench gets there by loading the slowest preset and letting it run a few cycles, so that low-order carries are active. It then reloads with the fastest preset and checks that expiry follows the new preset exactly. A second directed case reloads after expiry, so the sticky flag has to be cleared while the pulse history register still holds a high value.

// File: rtl/csatmr_pkg.sv
package csatmr_pkg;

   // Smallest width for which the redundant state has at least one sum bit.
   localparam int MIN_W = 2;

   // Cycles after the load cycle during which the level stays low;
   // the level first rises on cycle gap+1.
   function automatic longint unsigned expiry_gap(input int w, input longint unsigned p);
      return (longint'(1) << w) + longint'(w) - 2 - p;
   endfunction

endpackage

// File: rtl/csatmr_cell.sv
// One bit slice of the redundant counter: a half adder on the slice's own
// sum and carry bits, with the load path muxed in front of both registers.
module csatmr_cell (
   input  logic load_i,
   input  logic pre_i,
   input  logic sum_i,
   input  logic car_i,
   output logic sum_o,
   output logic car_o
);

   always_comb begin
      if (load_i) begin
         sum_o = pre_i;
         car_o = 1'b0;
      end else begin
         sum_o = sum_i ^ car_i;
         car_o = sum_i & car_i;
      end
   end

endmodule

// File: rtl/csatmr_core.sv
module csatmr_core
   import csatmr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         load_i,
   input  logic [W-1:0] preset_i,
   output logic         done_lvl_o
);

   localparam int R  = W - 1;
   localparam int NW = W + 2;
   localparam logic [NW-1:0] GAP_BASE = NW'(expiry_gap(W, 0));

   logic [R-1:0] sum_q, sum_d;
   logic [R:0]   car_q, car_d;
   logic [R:1]   car_up_d;
   logic         car0_d;
   logic         exp_q, exp_d;

   for (genvar i = 0; i < R; i++) begin : g_slice
      csatmr_cell u_cell (
         .load_i (load_i),
         .pre_i  (preset_i[i+1]),
         .sum_i  (sum_q[i]),
         .car_i  (car_q[i]),
         .sum_o  (sum_d[i]),
         .car_o  (car_up_d[i+1])
      );
   end

   // Bit 0 of the carry vector is the increment: it toggles every cycle.
   assign car0_d = load_i ? preset_i[0] : ~car_q[0];
   assign car_d  = {car_up_d, car0_d};

   assign exp_d = load_i ? 1'b0 : (exp_q | car_q[R]);

   always_ff @(posedge clk_i) begin
      sum_q <= sum_d;
      car_q <= car_d;
      exp_q <= exp_d;
   end

   assign done_lvl_o = exp_d;

   // ---------------- checking state and assertions ----------------
   logic          seen_q = 1'b0;
   logic [NW-1:0] since_q = '0;
   logic [NW-1:0] gap_q = '0;

   always_ff @(posedge clk_i) begin
      if (load_i) begin
         seen_q  <= 1'b1;
         since_q <= NW'(1);
         gap_q   <= GAP_BASE - NW'(preset_i);
      end else if (since_q != '1) begin
         since_q <= since_q + NW'(1);
      end
   end

   // R3 / R6: the redundant count expires after exactly gap+1 cycles
   assert_expiry_time_R3: assert property (@(posedge clk_i) disable iff (!seen_q)
      !load_i |-> (done_lvl_o == (since_q > gap_q)));

   // R1: the first cycle after a load never shows expiry
   assert_load_restart_R1: assert property (@(posedge clk_i) disable iff (!seen_q)
      load_i |=> (load_i || !done_lvl_o));

   // R4: expiry is sticky until a load
   assert_sticky_done_R4: assert property (@(posedge clk_i) disable iff (!seen_q)
      (done_lvl_o && !load_i) |=> (done_lvl_o || load_i));

endmodule

// File: rtl/csatmr_edge.sv
// Rising-edge detector on the expiry level.
module csatmr_edge (
   input  logic clk_i,
   input  logic lvl_i,
   output logic pulse_o
);

   logic prev_q;

   always_ff @(posedge clk_i) prev_q <= lvl_i;

   assign pulse_o = lvl_i & ~prev_q;

endmodule

// File: rtl/csa_expiry_timer.sv
module csa_expiry_timer
   import csatmr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         load_i,
   input  logic [W-1:0] preset_i,
   output logic         done_o,
   output logic         done_pulse_o
);

   // R8: elaboration-time width check
   if (W < MIN_W) begin : g_bad_width
      $error("csa_expiry_timer: W must be at least %0d", MIN_W);
   end

   logic done_lvl;

   csatmr_core #(.W(W)) u_core (
      .clk_i      (clk_i),
      .load_i     (load_i),
      .preset_i   (preset_i),
      .done_lvl_o (done_lvl)
   );

   csatmr_edge u_edge (
      .clk_i   (clk_i),
      .lvl_i   (done_lvl),
      .pulse_o (done_pulse_o)
   );

   assign done_o = done_lvl;

   logic armed_q = 1'b0;
   always_ff @(posedge clk_i) if (load_i) armed_q <= 1'b1;

   // R5: the pulse lasts one cycle
   assert_pulse_single_R5: assert property (@(posedge clk_i) disable iff (!armed_q)
      done_pulse_o |=> !done_pulse_o);

   // R5: a pulse only accompanies a high level
   assert_pulse_level_R5: assert property (@(posedge clk_i) disable iff (!armed_q)
      done_pulse_o |-> done_o);

endmodule

// File: tb/csa_expiry_timer_tb.sv
module csa_expiry_timer_tb;
   timeunit 1ns;
   timeprecision 1ps;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       ld4 = 1'b0;
   logic [3:0] pr4 = '0;
   logic       dn4, pl4;
   logic       ld6 = 1'b0;
   logic [5:0] pr6 = '0;
   logic       dn6, pl6;

   csa_expiry_timer #(.W(4)) u_dut (
      .clk_i(clk), .load_i(ld4), .preset_i(pr4), .done_o(dn4), .done_pulse_o(pl4));

   csa_expiry_timer #(.W(6)) u_dut6 (
      .clk_i(clk), .load_i(ld6), .preset_i(pr6), .done_o(dn6), .done_pulse_o(pl6));

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   // Entries: bit 8 selects the W=6 instance, bits 7:0 hold the preset.
   localparam int NVEC = 12;
   localparam int VEC [NVEC] = '{
      0, 1, 7, 8, 14, 15,
      256 + 0, 256 + 5, 256 + 31, 256 + 32, 256 + 62, 256 + 63
   };

   function automatic int gap(bit wide, int p);
      int w = wide ? 6 : 4;
      return (1 << w) + w - 2 - p;
   endfunction

   function automatic logic get_done(bit wide);
      return wide ? dn6 : dn4;
   endfunction

   function automatic logic get_pulse(bit wide);
      return wide ? pl6 : pl4;
   endfunction

   task automatic chk(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic drive(bit wide, int p, logic l);
      if (wide) begin ld6 = l; pr6 = p[5:0]; end
      else      begin ld4 = l; pr4 = p[3:0]; end
   endtask

   // Called at a falling edge; returns at the falling edge of cycle t+1.
   task automatic do_load(bit wide, int p, string req);
      drive(wide, p, 1'b1);
      #1;
      chk(req, "level during load", get_done(wide), 1'b0);
      chk(req, "pulse during load", get_pulse(wide), 1'b0);
      @(negedge clk);
      drive(wide, p, 1'b0);
   endtask

   // Observe cycles t+1 .. t+kmax.
   task automatic observe(bit wide, int n, int kmax);
      for (int k = 1; k <= kmax; k++) begin
         #1;
         if (k == 1) chk("R1", "level first cycle", get_done(wide), 1'b0);
         chk("R3", $sformatf("level k=%0d n=%0d", k, n), get_done(wide), logic'(k > n));
         chk("R5", $sformatf("pulse k=%0d n=%0d", k, n), get_pulse(wide), logic'(k == n + 1));
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      @(negedge clk);
      // Table sweep: R1, R2, R3, R5 for both widths
      for (int v = 0; v < NVEC; v++) begin
         bit wide = VEC[v][8];
         int p    = VEC[v] & 255;
         int n    = gap(wide, p);
         do_load(wide, p, "R2");
         observe(wide, n, n + 3);
      end

      // R6: reload with the fastest preset while the slowest is counting
      do_load(1'b0, 0, "R2");
      observe(1'b0, gap(1'b0, 0), 5);
      do_load(1'b0, 15, "R6");
      observe(1'b0, gap(1'b0, 15), gap(1'b0, 15) + 2);

      // R4: sticky level, no repeated pulse
      for (int k = 0; k < 12; k++) begin
         #1;
         chk("R4", "level held", dn4, 1'b1);
         chk("R4", "no repeat pulse", pl4, 1'b0);
         @(negedge clk);
      end

      // R7: reload after expiry
      do_load(1'b0, 8, "R7");
      for (int k = 1; k <= gap(1'b0, 8); k++) begin
         #1;
         chk("R7", "level low after reload", dn4, 1'b0);
         chk("R7", "pulse low after reload", pl4, 1'b0);
         @(negedge clk);
      end
      #1;
      chk("R7", "level rises on new expiry", dn4, 1'b1);
      chk("R7", "pulse on new expiry", pl4, 1'b1);
      @(negedge clk);

      // R6 on the wide instance: reload mid-count with the same preset
      do_load(1'b1, 40, "R2");
      observe(1'b1, gap(1'b1, 40), gap(1'b1, 40) - 3);
      do_load(1'b1, 40, "R6");
      observe(1'b1, gap(1'b1, 40), gap(1'b1, 40) + 2);

      finish_run();
   end

endmodule